// File: doc/BRIEF.md
# JTAG-to-AHB Memory Access Bridge

This block gives a JTAG debugger read and write access to memory over a single-beat AHB-Lite master port. A TAP controller outside the block selects a user data register and supplies capture, shift and update strobes in the TCK domain. While the bridge is selected, a 41-bit scan register sits between TDI and TDO. Every update hands the scanned word to the HCLK domain, where it becomes either a setup command or one bus beat.

A setup word (mode bit 0) loads the start address, the transfer width and an auto-increment count. A data word (mode bit 1) starts one transfer at the current address, and its direction bit chooses read or write. After each beat the address advances by the width in bytes for as many beats as the count allows. On the next capture the scan register loads the most recent read data, a done flag that shows whether the last update has been serviced, and a sticky bus-error flag. The host shifts these out on TDO.

Top module: `jtag_ahb_bridge`

## Requirements
- R1: After reset no bus transfer is issued (htrans_o = 0), and the first capture shifts out done = 1 with every other bit 0.
- R2: A capture loads the scan register as bit 40 = done (1 when no earlier update is still being serviced), bits 39:8 = last read data, bits 7:1 = 0 and bit 0 = sticky error flag. Bit 0 shifts out first.
- R3: A scanned word with bit 7 = 0 is a setup. Bits 39:8 set the address, bits 6:5 set the size and bits 4:1 set the increment count. A setup issues no bus transfer and clears the error flag.
- R4: A scanned word with bit 7 = 1 issues exactly one NONSEQ transfer at the current address, with hwrite_o equal to bit 0. On a write, bits 39:8 are driven as hwdata_o in the data phase.
- R5: Size 0 maps to hsize_o = 2 with a 4-byte step, size 1 or 2 maps to hsize_o = 1 with a 2-byte step, and size 3 maps to hsize_o = 0 with a 1-byte step.
- R6: After each data beat, if the remaining count is nonzero, the address advances by the step and the count drops by one. Otherwise the address stays where it is.
- R7: While hready_i is low, the address and control signals are held. The data phase ends at the first cycle with hready_i high, and a read takes hrdata_i in that cycle.
- R8: hresp_i high in the completing data-phase cycle sets the error flag, which stays set until the next setup.
- R9: An update that arrives while the previous one is still being serviced is ignored, and a capture made meanwhile shows done = 0.
- R10: Bit 40 of a scanned word has no effect.
- R11: htrans_o only ever takes IDLE (0) or NONSEQ (2), and each NONSEQ is accepted once and then followed by IDLE.
- R12: While sel_i is low, the capture, shift and update strobes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| hclk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| sel_i | input | 1 | Bridge data register selected by the TAP |
| capture_dr_i | input | 1 | Capture strobe (TCK domain) |
| shift_dr_i | input | 1 | Shift strobe (TCK domain) |
| update_dr_i | input | 1 | Update strobe (TCK domain) |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out, LSB of the scan register |
| haddr_o | output | 32 | Bus address |
| hsize_o | output | 3 | Bus transfer size |
| htrans_o | output | 2 | Bus transfer type |
| hwrite_o | output | 1 | Bus direction, 1 = write |
| hwdata_o | output | 32 | Bus write data |
| hrdata_i | input | 32 | Bus read data |
| hready_i | input | 1 | Bus ready |
| hresp_i | input | 1 | Bus error response |

## Verification
Write bursts run with zero to three wait states against a base address and an increment count of three. Five beats are issued each time, so the walk of the address and its stop at the end of the count both show, and so does any loss of a beat under stalls. Reads sweep all four size codes, each with an increment count of two, and a capture without update reads back each result. This separates the hsize mapping and the byte step of every code, and it exposes read data that is latched at the wrong edge. Error beats followed by good ones and then a setup distinguish sticky from per-beat error reporting. A bus stall much longer than one scan shows whether an update made while busy is dropped or queued.

// File: rtl/jab_pkg.sv
package jab_pkg;
  localparam int DATA_W = 32;
  localparam int INCR_W = 4;
  localparam int SIZE_W = 2;
  localparam int SCAN_W = 1 + DATA_W + 1 + SIZE_W + INCR_W + 1;
  localparam int PAD_W  = SCAN_W - DATA_W - 2;

  // layout from MSB: rsvd[40] payload[39:8] data_mode[7] size[6:5] incr[4:1] wr[0]
  typedef struct packed {
    logic              rsvd;
    logic [DATA_W-1:0] payload;
    logic              data_mode;
    logic [SIZE_W-1:0] size;
    logic [INCR_W-1:0] incr;
    logic              wr;
  } scan_word_t;

  typedef enum logic [1:0] {
    HT_IDLE   = 2'b00,
    HT_NONSEQ = 2'b10
  } htrans_e;

  typedef enum logic [1:0] {
    MS_IDLE,
    MS_ADDR,
    MS_DATA
  } mst_state_e;

  function automatic logic [2:0] hsize_of(logic [SIZE_W-1:0] s);
    case (s)
      2'd0:    return 3'd2;
      2'd3:    return 3'd0;
      default: return 3'd1;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] step_of(logic [SIZE_W-1:0] s);
    return DATA_W'(1) << hsize_of(s);
  endfunction
endpackage

// File: rtl/jab_sync.sv
module jab_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/jab_scan_tck.sv
module jab_scan_tck
  import jab_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              tck_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              capture_i,
  input  logic              shift_i,
  input  logic              update_i,
  input  logic              tdi_i,
  output logic              tdo_o,
  input  logic              ack_tgl_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              err_i,
  output logic              req_tgl_o,
  output scan_word_t        cmd_o
);
  logic [SCAN_W-1:0] sr_q;
  logic              req_q;
  logic              ack_s;
  logic              pending;
  scan_word_t        cmd_q;

  jab_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk_i  (tck_i),
    .rst_ni (rst_ni),
    .d_i    (ack_tgl_i),
    .q_o    (ack_s)
  );

  assign pending = req_q ^ ack_s;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      req_q <= 1'b0;
      cmd_q <= '0;
    end else if (sel_i) begin
      if (capture_i) begin
        // rdata/err are quiet whenever pending is low
        sr_q <= {~pending, rdata_i, {PAD_W{1'b0}}, err_i};
      end else if (shift_i) begin
        sr_q <= {tdi_i, sr_q[SCAN_W-1:1]};
      end else if (update_i && !pending) begin
        cmd_q <= scan_word_t'(sr_q);
        req_q <= ~req_q;
      end
    end
  end

  assign tdo_o     = sr_q[0];
  assign req_tgl_o = req_q;
  assign cmd_o     = cmd_q;
endmodule

// File: rtl/jab_ahb_master.sv
module jab_ahb_master
  import jab_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              hclk_i,
  input  logic              rst_ni,
  input  logic              req_tgl_i,
  input  scan_word_t        cmd_i,
  output logic              ack_tgl_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  output logic [DATA_W-1:0] haddr_o,
  output logic [2:0]        hsize_o,
  output logic [1:0]        htrans_o,
  output logic              hwrite_o,
  output logic [DATA_W-1:0] hwdata_o,
  input  logic [DATA_W-1:0] hrdata_i,
  input  logic              hready_i,
  input  logic              hresp_i
);
  mst_state_e        state_q;
  logic              req_s;
  logic              ack_q;
  logic [DATA_W-1:0] addr_q;
  logic [SIZE_W-1:0] size_q;
  logic [INCR_W-1:0] cnt_q;
  logic              wr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              err_q;
  logic              new_cmd;

  jab_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk_i  (hclk_i),
    .rst_ni (rst_ni),
    .d_i    (req_tgl_i),
    .q_o    (req_s)
  );

  assign new_cmd = (state_q == MS_IDLE) && (req_s != ack_q);

  always_ff @(posedge hclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= MS_IDLE;
      ack_q   <= 1'b0;
      addr_q  <= '0;
      size_q  <= '0;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        MS_IDLE: begin
          if (new_cmd) begin
            if (!cmd_i.data_mode) begin
              addr_q <= cmd_i.payload;
              size_q <= cmd_i.size;
              cnt_q  <= cmd_i.incr;
              err_q  <= 1'b0;
              ack_q  <= ~ack_q;
            end else begin
              wr_q    <= cmd_i.wr;
              wdata_q <= cmd_i.payload;
              state_q <= MS_ADDR;
            end
          end
        end
        MS_ADDR: begin
          if (hready_i) state_q <= MS_DATA;
        end
        MS_DATA: begin
          if (hready_i) begin
            if (!wr_q) rdata_q <= hrdata_i;
            if (hresp_i) err_q <= 1'b1;
            if (cnt_q != '0) begin
              addr_q <= addr_q + step_of(size_q);
              cnt_q  <= cnt_q - 1'b1;
            end
            ack_q   <= ~ack_q;
            state_q <= MS_IDLE;
          end
        end
        default: state_q <= MS_IDLE;
      endcase
    end
  end

  assign ack_tgl_o = ack_q;
  assign rdata_o   = rdata_q;
  assign err_o     = err_q;
  assign haddr_o   = addr_q;
  assign hsize_o   = hsize_of(size_q);
  assign htrans_o  = (state_q == MS_ADDR) ? HT_NONSEQ : HT_IDLE;
  assign hwrite_o  = wr_q;
  assign hwdata_o  = wdata_q;
endmodule

// File: rtl/jtag_ahb_bridge.sv
module jtag_ahb_bridge
  import jab_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              tck_i,
  input  logic              hclk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              capture_dr_i,
  input  logic              shift_dr_i,
  input  logic              update_dr_i,
  input  logic              tdi_i,
  output logic              tdo_o,
  output logic [DATA_W-1:0] haddr_o,
  output logic [2:0]        hsize_o,
  output logic [1:0]        htrans_o,
  output logic              hwrite_o,
  output logic [DATA_W-1:0] hwdata_o,
  input  logic [DATA_W-1:0] hrdata_i,
  input  logic              hready_i,
  input  logic              hresp_i
);
  logic              req_tgl;
  logic              ack_tgl;
  scan_word_t        cmd;
  logic [DATA_W-1:0] rdata;
  logic              err;

  jab_scan_tck #(.SYNC_STAGES(SYNC_STAGES)) u_scan (
    .tck_i     (tck_i),
    .rst_ni    (rst_ni),
    .sel_i     (sel_i),
    .capture_i (capture_dr_i),
    .shift_i   (shift_dr_i),
    .update_i  (update_dr_i),
    .tdi_i     (tdi_i),
    .tdo_o     (tdo_o),
    .ack_tgl_i (ack_tgl),
    .rdata_i   (rdata),
    .err_i     (err),
    .req_tgl_o (req_tgl),
    .cmd_o     (cmd)
  );

  jab_ahb_master #(.SYNC_STAGES(SYNC_STAGES)) u_mst (
    .hclk_i    (hclk_i),
    .rst_ni    (rst_ni),
    .req_tgl_i (req_tgl),
    .cmd_i     (cmd),
    .ack_tgl_o (ack_tgl),
    .rdata_o   (rdata),
    .err_o     (err),
    .haddr_o   (haddr_o),
    .hsize_o   (hsize_o),
    .htrans_o  (htrans_o),
    .hwrite_o  (hwrite_o),
    .hwdata_o  (hwdata_o),
    .hrdata_i  (hrdata_i),
    .hready_i  (hready_i),
    .hresp_i   (hresp_i)
  );
endmodule

// File: rtl/jab_bridge_chk.sv
module jab_bridge_chk (
  input logic        hclk_i,
  input logic        rst_ni,
  input logic [1:0]  htrans_o,
  input logic        hready_i,
  input logic [31:0] haddr_o,
  input logic [2:0]  hsize_o,
  input logic        hwrite_o
);
  // R11
  htrans_legal_chk: assert property (@(posedge hclk_i) disable iff (!rst_ni)
    (htrans_o == 2'b00) || (htrans_o == 2'b10));

  // R7
  addr_hold_chk: assert property (@(posedge hclk_i) disable iff (!rst_ni)
    (htrans_o == 2'b10 && !hready_i) |=>
      (htrans_o == 2'b10 && $stable(haddr_o) && $stable(hsize_o) && $stable(hwrite_o)));

  // R11
  one_beat_chk: assert property (@(posedge hclk_i) disable iff (!rst_ni)
    (htrans_o == 2'b10 && hready_i) |=> (htrans_o == 2'b00));

  // R5
  hsize_legal_chk: assert property (@(posedge hclk_i) disable iff (!rst_ni)
    (htrans_o == 2'b10) |-> (hsize_o <= 3'd2));
endmodule

bind jtag_ahb_bridge jab_bridge_chk u_chk (.*);

// File: tb/tb_jtag_ahb_bridge.sv
module tb_jtag_ahb_bridge;
  localparam logic [31:0] ERR_ADDR = 32'h0000_00F0;

  logic        tck = 1'b0;
  logic        hclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, cap_s = 1'b0, sh_s = 1'b0, up_s = 1'b0, tdi = 1'b0;
  logic        tdo;
  logic [31:0] haddr, hwdata, hrdata;
  logic [2:0]  hsize;
  logic [1:0]  htrans;
  logic        hwrite, hready, hresp;

  always #5ns  hclk = ~hclk;
  always #20ns tck  = ~tck;

  jtag_ahb_bridge dut (
    .tck_i(tck), .hclk_i(hclk), .rst_ni(rst_n), .sel_i(sel),
    .capture_dr_i(cap_s), .shift_dr_i(sh_s), .update_dr_i(up_s),
    .tdi_i(tdi), .tdo_o(tdo),
    .haddr_o(haddr), .hsize_o(hsize), .htrans_o(htrans), .hwrite_o(hwrite),
    .hwdata_o(hwdata), .hrdata_i(hrdata), .hready_i(hready), .hresp_i(hresp)
  );

  // bus slave model
  logic [31:0] mem [64];
  logic        dp_valid, dp_write;
  logic [31:0] dp_addr;
  int          ws_cfg = 0;
  int          ws_left;
  int          xfer_cnt;
  logic [31:0] last_addr;
  logic [2:0]  last_size;
  logic        last_write;

  function automatic logic [31:0] mem_init(int i);
    return 32'hC0DE_0000 + 32'(i) * 32'h0000_0111;
  endfunction

  assign hready = !dp_valid || (ws_left == 0);
  assign hrdata = mem[dp_addr[7:2]];
  assign hresp  = dp_valid && (dp_addr == ERR_ADDR);

  always @(posedge hclk or negedge rst_n) begin
    if (!rst_n) begin
      dp_valid <= 1'b0; dp_write <= 1'b0; dp_addr <= '0; ws_left <= 0; xfer_cnt <= 0;
      last_addr <= '0; last_size <= '0; last_write <= 1'b0;
      for (int i = 0; i < 64; i++) mem[i] <= mem_init(i);
    end else begin
      if (dp_valid) begin
        if (ws_left != 0) ws_left <= ws_left - 1;
        else begin
          if (dp_write) mem[dp_addr[7:2]] <= hwdata;
          xfer_cnt <= xfer_cnt + 1;
          dp_valid <= 1'b0;
        end
      end
      if (htrans == 2'b10 && hready) begin
        dp_valid <= 1'b1; dp_addr <= haddr; dp_write <= hwrite; ws_left <= ws_cfg;
        last_addr <= haddr; last_size <= hsize; last_write <= hwrite;
      end
    end
  end

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic logic [40:0] mk(logic dm, logic wr, logic [1:0] sz, logic [3:0] inc,
                                     logic [31:0] pay, logic rsvd);
    return {rsvd, pay, dm, sz, inc, wr};
  endfunction

  function automatic logic [40:0] capw(logic done, logic [31:0] rd, logic err);
    return {done, rd, 7'b0, err};
  endfunction

  task automatic scan(input logic [40:0] w, input logic do_upd, input logic s, output logic [40:0] got);
    @(negedge tck); sel = s; cap_s = 1'b1;
    @(negedge tck); cap_s = 1'b0; sh_s = 1'b1; tdi = w[0]; got[0] = tdo;
    for (int i = 1; i < 41; i++) begin
      @(negedge tck); tdi = w[i]; got[i] = tdo;
    end
    @(negedge tck); sh_s = 1'b0; up_s = do_upd;
    @(negedge tck); up_s = 1'b0; sel = 1'b0;
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge tck);
  endtask

  initial begin
    #1500us;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [40:0] got;
    logic [31:0] data, exp_addr, base, step;
    logic [2:0]  exp_sz;
    int          xc;

    settle(3);
    rst_n = 1'b1;
    settle(2);

    // R1 / R2: reset state
    check("R1", "htrans after reset", 64'(htrans), 64'd0);
    scan(mk(0, 0, 0, 0, 32'h0, 0), 1, 1, got);
    check("R1", "reset capture", 64'(got), 64'(capw(1, 32'h0, 0)));
    settle(30);
    check("R3", "setup issues no transfer", 64'(xfer_cnt), 64'd0);

    // word write bursts across wait-state counts (R4 R6 R7)
    for (int ws = 0; ws < 4; ws++) begin
      ws_cfg = ws;
      base = 32'(ws * 16);
      scan(mk(0, 0, 2'd0, 4'd3, base, 0), 1, 1, got);
      settle(30);
      for (int k = 0; k < 5; k++) begin
        xc = xfer_cnt;
        data = 32'h1000_0000 + 32'(ws * 16 + k);
        scan(mk(1, 1, 2'd0, 4'd0, data, 0), 1, 1, got);
        settle(30);
        exp_addr = base + 32'(4 * ((k < 3) ? k : 3));
        check("R6", "write beat address", 64'(last_addr), 64'(exp_addr));
        check("R4", "write direction", 64'(last_write), 64'd1);
        check("R5", "word hsize", 64'(last_size), 64'd2);
        check("R4", "one transfer per update", 64'(xfer_cnt), 64'(xc + 1));
        check("R7", "written data", 64'(mem[exp_addr[7:2]]), 64'(data));
      end
    end

    // reads over every size code (R5 R6 R7 R2)
    for (int sz = 0; sz < 4; sz++) begin
      ws_cfg = 3 - sz;
      base = 32'h40 + 32'(sz * 16);
      exp_sz = (sz == 0) ? 3'd2 : (sz == 3) ? 3'd0 : 3'd1;
      step = 32'd1 << exp_sz;
      scan(mk(0, 0, 2'(sz), 4'd2, base, 0), 1, 1, got);
      settle(30);
      for (int k = 0; k < 3; k++) begin
        scan(mk(1, 0, 2'd0, 4'd0, 32'hFFFF_FFFF, 0), 1, 1, got);
        settle(30);
        exp_addr = base + step * 32'(k);
        check("R6", "read beat address", 64'(last_addr), 64'(exp_addr));
        check("R5", "read hsize", 64'(last_size), 64'(exp_sz));
        check("R4", "read direction", 64'(last_write), 64'd0);
        scan(41'h0, 0, 1, got);
        check("R2", "read capture", 64'(got), 64'(capw(1, mem_init(int'(exp_addr[7:2])), 0)));
      end
    end
    ws_cfg = 0;

    // sticky error (R8) and clear by setup (R3)
    scan(mk(0, 0, 2'd0, 4'd1, ERR_ADDR, 0), 1, 1, got);
    settle(30);
    scan(mk(1, 1, 2'd0, 4'd0, 32'hDEAD_0001, 0), 1, 1, got);
    settle(30);
    scan(41'h0, 0, 1, got);
    check("R8", "error flag after error beat", 64'(got[0]), 64'd1);
    scan(mk(1, 0, 2'd0, 4'd0, 32'h0, 0), 1, 1, got);
    settle(30);
    check("R6", "address after error beat", 64'(last_addr), 64'(ERR_ADDR + 4));
    scan(41'h0, 0, 1, got);
    check("R8", "error flag sticky over good beat", 64'(got),
          64'(capw(1, mem_init(int'(ERR_ADDR[7:2]) + 1), 1)));
    scan(mk(0, 0, 2'd0, 4'd0, 32'h0, 0), 1, 1, got);
    settle(30);
    scan(41'h0, 0, 1, got);
    check("R3", "setup clears error", 64'(got[0]), 64'd0);

    // reserved bit ignored (R10)
    scan(mk(0, 0, 2'd0, 4'd0, 32'h20, 1), 1, 1, got);
    settle(30);
    scan(mk(1, 1, 2'd0, 4'd0, 32'h5A5A_0020, 1), 1, 1, got);
    settle(30);
    check("R10", "address with bit 40 set", 64'(last_addr), 64'h20);
    check("R10", "data with bit 40 set", 64'(mem[8]), 64'h5A5A_0020);

    // not selected (R12)
    xc = xfer_cnt;
    scan(mk(1, 1, 2'd0, 4'd0, 32'h0BAD_0BAD, 0), 1, 0, got);
    settle(30);
    check("R12", "no transfer when unselected", 64'(xfer_cnt), 64'(xc));
    check("R12", "memory untouched when unselected", 64'(mem[8]), 64'h5A5A_0020);

    // update while busy (R9)
    scan(mk(0, 0, 2'd0, 4'd0, 32'h24, 0), 1, 1, got);
    settle(30);
    ws_cfg = 400;
    xc = xfer_cnt;
    scan(mk(1, 1, 2'd0, 4'd0, 32'h1111_AAAA, 0), 1, 1, got);
    scan(mk(1, 1, 2'd0, 4'd0, 32'h2222_BBBB, 0), 1, 1, got);
    check("R9", "done flag while busy", 64'(got[40]), 64'd0);
    settle(150);
    check("R9", "only first update served", 64'(xfer_cnt), 64'(xc + 1));
    check("R9", "first data kept", 64'(mem[9]), 64'h1111_AAAA);
    ws_cfg = 0;
    scan(41'h0, 0, 1, got);
    check("R2", "done flag after stall", 64'(got[40]), 64'd1);

    report();
  end
endmodule